// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a flash device. It waits for a program or erase operation that is already under way to finish. A pulse on `start` latches a poll address. The block then reads the device status byte in back-to-back pairs over a level request / single-cycle valid read port. After each pair it compares the toggle bit (bit 6) of the two reads. When the bit holds steady, the operation has finished and the block pulses `done`.

While bit 6 keeps changing, the block looks at the time-limit flag (bit 5) of the newer read of the pair. A clear flag means the block reads another pair. A set flag means the block reads exactly one more pair and tests bit 6 again, because toggling can stop in the same moment the flag rises. If that last pair still toggles, the block writes a reset command byte to the poll address, waits for the write acknowledge, and then pulses `fail`. A parameter can limit the number of pairs. When the limit is reached, the block takes the same failure path.

Top module: `tglpoll_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done`, `fail`, `rd_req` and `wr_req` are all 0.
- R2: A `start` seen while idle makes `busy` and `rd_req` go high in the next cycle, with `rd_addr` equal to the `poll_addr` sampled with `start`. Reads are issued one at a time, and `rd_req` stays high until `rd_valid` is seen.
- R3: If bit 6 is equal in both reads of a pair, `done` pulses for one cycle and `busy` is 0 in that cycle. No write is issued.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 0, a new pair of reads is started. Bit 5 of the first read is ignored.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly one more pair is read. If bit 6 is then equal, `done` pulses.
- R6: If bit 6 differs in that extra pair, `wr_req` rises with `wr_data` = RST_CMD (default 0xF0) and `wr_addr` = poll address. `wr_req` is held until `wr_ack`, and `fail` pulses in the cycle after the acknowledge.
- R7: With MAX_PAIRS > 0, a run whose first MAX_PAIRS pairs all toggle with bit 5 clear ends through the R6 write-and-fail path after exactly MAX_PAIRS pairs. MAX_PAIRS = 0 removes the limit.
- R8: A `start` while busy is ignored and does not change the reads issued or the outcome.
- R9: `done` and `fail` are never high together, each run produces exactly one of them, and each is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (used only when idle) |
| poll_addr | input | AW | Address used for status reads and the reset write |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | AW | Read address |
| rd_data | input | DW | Read data, qualified by rd_valid |
| rd_valid | input | 1 | One-cycle read completion |
| wr_req | output | 1 | Reset-command write request, held until wr_ack |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Reset command byte |
| wr_ack | input | 1 | One-cycle write acknowledge |
| busy | output | 1 | High from start until the outcome pulse |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
A wrong pair index or a lost capture register shows up at the ports as a wrong number of read handshakes before the outcome pulse. The outcome can also flip between `done` and `fail`. This is visible as soon as the first pair that should have ended the run is evaluated, so the bench counts reads per run and compares them with the count expected from the status sequence. A stuck recheck flag or a test of bit 5 on the wrong read changes whether a write appears. One of the status sequences sets bit 5 only in the older read, which makes the second of these faults lead to a premature failure. An off-by-one in the pair limit changes the read count of the limit run by exactly two.

// File: rtl/tglpoll_pkg.sv
package tglpoll_pkg;
  localparam int TGL_BIT = 6;
  localparam int LIM_BIT = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_RSTW = 2'd2
  } poll_st_t;
endpackage

// File: rtl/tglpoll_rdport.sv
module tglpoll_rdport #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic          pair_vld,
  output logic [DW-1:0] first_q,
  output logic [DW-1:0] second_q
);
  logic idx;
  logic relaunch;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req   <= 1'b0;
      pair_vld <= 1'b0;
      idx      <= 1'b0;
      relaunch <= 1'b0;
      first_q  <= '0;
      second_q <= '0;
    end else begin
      pair_vld <= 1'b0;
      if (go) begin
        rd_req <= 1'b1;
        idx    <= 1'b0;
      end else if (rd_req && rd_valid) begin
        rd_req <= 1'b0;
        if (!idx) begin
          first_q  <= rd_data;
          relaunch <= 1'b1;
        end else begin
          second_q <= rd_data;
          pair_vld <= 1'b1;
        end
      end else if (relaunch) begin
        rd_req   <= 1'b1;
        idx      <= 1'b1;
        relaunch <= 1'b0;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> rd_req); // R2
  AST_PAIR_PULSE: assert property (@(posedge clk) disable iff (rst)
    pair_vld |=> !pair_vld); // R2
endmodule

// File: rtl/tglpoll_limit.sv
module tglpoll_limit #(
  parameter int MAX_PAIRS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  generate
    if (MAX_PAIRS == 0) begin : g_unlimited
      logic unused_lim;
      assign unused_lim = &{1'b0, clk, rst, clr, inc};
      assign last = 1'b0;
    end else begin : g_limited
      localparam int CW = $clog2(MAX_PAIRS + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc && !last) cnt <= cnt + 1'b1;
      end
      assign last = (cnt == CW'(MAX_PAIRS - 1));
      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(MAX_PAIRS)); // R7
    end
  endgenerate
endmodule

// File: rtl/tglpoll_ctrl.sv
module tglpoll_ctrl
  import tglpoll_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          MAX_PAIRS = 1024,
  parameter logic [DW-1:0] RST_CMD = DW'(8'hF0)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] poll_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_valid,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          busy,
  output logic          done,
  output logic          fail
);
  poll_st_t      st;
  logic [AW-1:0] addr_q;
  logic          late;
  logic          pair_vld;
  logic [DW-1:0] first_q, second_q;
  logic          tgl, lim_flag, last, go, clr;

  assign tgl      = first_q[TGL_BIT] ^ second_q[TGL_BIT];
  assign lim_flag = second_q[LIM_BIT];
  assign clr      = (st == ST_IDLE) && start;
  assign go       = clr ||
                    ((st == ST_POLL) && pair_vld && tgl && !late && (lim_flag || !last));

  tglpoll_rdport #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .go(go), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_req(rd_req), .pair_vld(pair_vld), .first_q(first_q), .second_q(second_q)
  );

  tglpoll_limit #(.MAX_PAIRS(MAX_PAIRS)) u_lim (
    .clk(clk), .rst(rst), .clr(clr),
    .inc((st == ST_POLL) && pair_vld), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      late   <= 1'b0;
      wr_req <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_POLL;
          busy   <= 1'b1;
          addr_q <= poll_addr;
          late   <= 1'b0;
        end
        ST_POLL: if (pair_vld) begin
          if (!tgl) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else if (late) begin
            wr_req <= 1'b1;
            st     <= ST_RSTW;
          end else if (lim_flag) begin
            late <= 1'b1;
          end else if (last) begin
            wr_req <= 1'b1;
            st     <= ST_RSTW;
          end
        end
        ST_RSTW: if (wr_ack) begin
          wr_req <= 1'b0;
          fail   <= 1'b1;
          busy   <= 1'b0;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr = addr_q;
  assign wr_addr = addr_q;
  assign wr_data = RST_CMD;

  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && fail)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_ack |=> wr_req); // R6
  AST_FAIL_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    fail |-> $past(wr_req && wr_ack)); // R6
  AST_NO_RD_IN_WR: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> !rd_req); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req && !wr_req); // R2
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !busy); // R3
endmodule

// File: tb/sim_tglpoll_ctrl.sv
`timescale 1ns/1ps
module sim_tglpoll_ctrl;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic rd_req, wr_req, busy, done, fail;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic rd_valid, wr_ack;

  always #2.5 clk = ~clk;

  tglpoll_ctrl #(.AW(AW), .DW(DW), .MAX_PAIRS(LIM)) u0 (
    .clk(clk), .rst(rst), .start(start), .poll_addr(poll_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done), .fail(fail)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] rsp [0:31];
  int rsp_n = 0;
  int ri = 0;
  logic [AW-1:0] exp_addr = '0;
  int addr_bad = 0;
  int wr_seen = 0;
  logic [DW-1:0] wr_d;
  logic [AW-1:0] wr_a;
  int done_n = 0, fail_n = 0, both_n = 0, dwide_n = 0, busy_at_end = 0;
  logic done_prev = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // read responder: one-cycle valid, latency of one idle cycle
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rd_req && !rd_valid) begin
        @(negedge clk);
        rd_data  = (ri < rsp_n) ? rsp[ri] : ((ri % 2 == 1) ? 8'h40 : 8'h00);
        if (rd_addr != exp_addr) addr_bad++;
        ri++;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end
  end

  // write responder
  initial begin
    wr_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (wr_req && !wr_ack) begin
        wr_seen++;
        wr_d = wr_data;
        wr_a = wr_addr;
        repeat (2) @(negedge clk);
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (done) done_n++;
    if (fail) fail_n++;
    if (done && fail) both_n++;
    if (done && done_prev) dwide_n++;
    if ((done || fail) && busy) busy_at_end++;
    done_prev = done;
  end

  task automatic run(input string req, input logic [AW-1:0] a, input int extra_start,
                     input int exp_done, input int exp_reads, input int exp_wr);
    ri = 0; done_n = 0; fail_n = 0; wr_seen = 0; addr_bad = 0;
    both_n = 0; dwide_n = 0; busy_at_end = 0;
    exp_addr = a;
    @(negedge clk);
    poll_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    poll_addr = ~a;
    check({req, " R2 busy after start"}, busy, 1);
    check({req, " R2 rd_req after start"}, rd_req, 1);
    for (int k = 0; k < 2000 && (done_n + fail_n) == 0; k++) begin
      if (k == 5 && extra_start != 0) start = 1'b1;   // R8 mid-run start
      if (k == 6) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (8) @(negedge clk);
    check({req, " R9 outcomes"}, done_n + fail_n, 1);
    check({req, " R9 overlap/width"}, both_n + dwide_n, 0);
    check({req, " R3 busy low at outcome"}, busy_at_end, 0);
    check({req, " done"}, done_n, exp_done);
    check({req, " read count"}, ri, exp_reads);
    check({req, " R2 read address"}, addr_bad, 0);
    check({req, " R6 write count"}, wr_seen, exp_wr);
    if (exp_wr != 0) begin
      check({req, " R6 wr_data"}, wr_d, 8'hF0);
      check({req, " R6 wr_addr"}, wr_a, a);
    end
    check({req, " idle after"}, busy, 0);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 done/fail", done | fail, 0);
    check("R1 rd_req/wr_req", rd_req | wr_req, 0);
  endtask

  task automatic t_steady;   // R3: no toggle in first pair
    rsp[0] = 8'h40; rsp[1] = 8'h40; rsp_n = 2;
    run("R3", 16'h1234, 0, 1, 2, 0);
  endtask

  task automatic t_retry;    // R4: bit5 only in older read must be ignored
    rsp[0] = 8'h20; rsp[1] = 8'h40; rsp[2] = 8'h00; rsp[3] = 8'h40;
    rsp[4] = 8'h44; rsp[5] = 8'h44; rsp_n = 6;
    run("R4", 16'h00A0, 0, 1, 6, 0);
  endtask

  task automatic t_late_ok;  // R5: flag set, then toggling stops
    rsp[0] = 8'h00; rsp[1] = 8'h60; rsp[2] = 8'h20; rsp[3] = 8'h20; rsp_n = 4;
    run("R5", 16'hBEEF, 0, 1, 4, 0);
  endtask

  task automatic t_late_fail; // R6: flag set, still toggling
    rsp[0] = 8'h00; rsp[1] = 8'h60; rsp[2] = 8'h60; rsp[3] = 8'h20; rsp_n = 4;
    run("R6", 16'h0F0F, 0, 0, 4, 1);
  endtask

  task automatic t_limit;    // R7: endless toggling with flag clear
    rsp_n = 0;
    run("R7", 16'h5555, 0, 0, 2 * LIM, 1);
  endtask

  task automatic t_restart;  // R8: start pulse while busy
    rsp[0] = 8'h00; rsp[1] = 8'h40; rsp[2] = 8'h00; rsp[3] = 8'h40;
    rsp[4] = 8'h40; rsp[5] = 8'h40; rsp_n = 6;
    run("R8", 16'h7777, 1, 1, 6, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_steady();
    t_retry();
    t_late_ok();
    t_late_fail();
    t_limit();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule